// File: doc/BRIEF.md
# Burst Fragmenter With Early Acknowledge

This block sits between a requester and a memory target on a split request/response bus. Logical transfers of up to `2**MAX_LG` bytes come in from the requester. The target only handles aligned transfers of at most `2**TGT_LG` bytes. The block turns each logical transfer into a run of aligned fragments. Read-type requests and hints are one header beat upstream and become one downstream request per fragment. Write-type requests carry one data beat of `2**MIN_LG` bytes per cycle, and each beat is forwarded with the address and size of the fragment it belongs to.

Every downstream request carries three flags: first fragment, last fragment, and forward-acknowledge. It also carries its fragment size and the requester's tag. An in-order target returns these flags and fields unchanged with its responses. The response side uses them to pass every read data beat through in address order. It also cuts the per-fragment write acknowledgements down to exactly one. The fragment that supplies that acknowledgement depends on a three-way policy. A hold-denied option copies the denied status of a read burst's first beat onto the rest of that burst. A forced-minimum option splits everything to `2**MIN_LG` bytes.

Top module: `burst_fragmenter`

## Requirements
- R1: A read (op 0) or hint (op 5) of size S is issued as max(1, 2**(S-F)) downstream requests of size F = min(S, cut), where cut is TGT_LG, or MIN_LG when FORCE_MIN is set. The upstream header is accepted (`up_ready`=1) only in the cycle its final fragment is accepted.
- R2: With FORCE_MIN set, reads, hints and writes are split into fragments of size MIN_LG.
- R3: Fragment k has address (addr & ~(2**S-1)) + k*2**F. `dn_first` is 1 only for k=0 and `dn_last` is 1 only for the final fragment.
- R4: Full writes (op 1), partial writes (op 2) and logical atomics (op 3) pass each upstream beat through as one downstream beat with `up_ready` equal to `dn_ready`. Beat i carries the size, address and first/last flags of fragment floor(i / 2**(F-MIN_LG)).
- R5: An arithmetic atomic (op 4) is a single downstream beat with first and last both set. Its size is the request size, clamped to MIN_LG when FORCE_MIN is set.
- R6: With ACK_POLICY 0, only the acknowledgement of the last fragment of a write reaches the requester. Exactly one acknowledgement is delivered per original write.
- R7: With ACK_POLICY 1, full and partial writes are acknowledged with the first fragment's acknowledgement, and later ones are dropped.
- R8: With ACK_POLICY 2, full writes use the first fragment's acknowledgement and partial writes the last one. Hints use the last fragment's acknowledgement under every policy.
- R9: Every read data beat (`tr_has_data`=1) reaches the requester in arrival order with its data and original tag.
- R10: With HOLD_DENY set, every beat of a read burst reports the denied status of the burst's first beat. Without it, each beat reports its own status.
- R11: After reset no fragmentation is in progress. The first request starts at fragment 0, and nothing is presented on either side without an input valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted |
| up_op | input | 3 | Operation code (0 read, 1 full write, 2 partial write, 3 logical atomic, 4 arithmetic atomic, 5 hint) |
| up_size | input | SZ_W | log2 of transfer bytes |
| up_addr | input | ADDR_W | Byte address |
| up_tag | input | TAG_W | Requester transaction tag |
| up_data | input | DATA_W | Write data beat |
| dn_valid | output | 1 | Fragment request valid |
| dn_ready | input | 1 | Target accepts fragment beat |
| dn_op | output | 3 | Operation code |
| dn_size | output | SZ_W | Fragment size, log2 bytes |
| dn_addr | output | ADDR_W | Fragment address |
| dn_tag | output | TAG_W | Tag, echoed by target |
| dn_data | output | DATA_W | Write data beat |
| dn_first | output | 1 | First fragment flag, echoed |
| dn_last | output | 1 | Last fragment flag, echoed |
| dn_fwd | output | 1 | Forward-acknowledge flag, echoed |
| tr_valid | input | 1 | Target response valid |
| tr_ready | output | 1 | Target response accepted |
| tr_has_data | input | 1 | Response is a data beat (else acknowledgement) |
| tr_size | input | SZ_W | Echoed fragment size |
| tr_tag | input | TAG_W | Echoed tag |
| tr_data | input | DATA_W | Read data |
| tr_denied | input | 1 | Fragment denied |
| tr_first | input | 1 | Echoed first flag |
| tr_last | input | 1 | Echoed last flag |
| tr_fwd | input | 1 | Echoed forward flag |
| rp_valid | output | 1 | Response to requester valid |
| rp_ready | input | 1 | Requester accepts response |
| rp_has_data | output | 1 | Response is a data beat |
| rp_tag | output | TAG_W | Original tag |
| rp_data | output | DATA_W | Read data |
| rp_denied | output | 1 | Denied status |

## Verification
The bench targets unaligned start addresses. A fragmenter that does not clear the low address bits would emit fragments that cross target boundaries. It checks that the upstream header of a read or hint is held until the final fragment; releasing it early would lose the rest of the burst. It replays acknowledgements under all three policies, for both write kinds and for hints, and confirms that exactly one arrives and from the expected fragment. A duplicated or misplaced acknowledgement would tell the requester a write finished too early or twice. It also drives read bursts whose first beat is denied and whose later beats are not, and the reverse, so that a design which latches the wrong beat or ignores the hold option gives the wrong status on some beat.

// File: rtl/frag_pkg.sv
package frag_pkg;

  typedef enum logic [2:0] {
    OP_GET       = 3'd0,
    OP_PUT_FULL  = 3'd1,
    OP_PUT_PART  = 3'd2,
    OP_LOGIC     = 3'd3,
    OP_ARITH     = 3'd4,
    OP_HINT      = 3'd5
  } frag_op_e;

  localparam int ACK_ON_LAST    = 0;
  localparam int ACK_ALL_FIRST  = 1;
  localparam int ACK_FULL_FIRST = 2;

  // Upstream request carries a data beat per cycle
  function automatic logic op_carries_data(frag_op_e op);
    return (op == OP_PUT_FULL) || (op == OP_PUT_PART) ||
           (op == OP_LOGIC) || (op == OP_ARITH);
  endfunction

  // Target answers with data beats rather than one acknowledgement
  function automatic logic op_returns_data(frag_op_e op);
    return (op == OP_GET) || (op == OP_LOGIC) || (op == OP_ARITH);
  endfunction

  // Fragment size (log2 bytes) for a request of size sz
  function automatic int frag_lg(logic arith, int sz, int min_lg, int cut_lg, int force_min);
    if (arith) return (force_min != 0 && sz > min_lg) ? min_lg : sz;
    return (sz > cut_lg) ? cut_lg : sz;
  endfunction

  // Data beats for a transfer of size lg on a 2**min_lg byte bus
  function automatic int beats_of(int lg, int min_lg);
    return 1 << ((lg > min_lg ? lg : min_lg) - min_lg);
  endfunction

  // Whether the acknowledgement is taken from the first fragment
  function automatic logic ack_early(int pol, frag_op_e op);
    return (pol == ACK_ALL_FIRST && (op == OP_PUT_FULL || op == OP_PUT_PART)) ||
           (pol == ACK_FULL_FIRST && op == OP_PUT_FULL);
  endfunction

endpackage

// File: rtl/frag_req_split.sv
module frag_req_split
  import frag_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int TAG_W      = 4,
  parameter int SZ_W       = 4,
  parameter int MIN_LG     = 2,
  parameter int MAX_LG     = 6,
  parameter int TGT_LG     = 4,
  parameter int FORCE_MIN  = 0,
  parameter int ACK_POLICY = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  frag_op_e          req_op,
  input  logic [SZ_W-1:0]   req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [DATA_W-1:0] req_data,
  output logic              a_valid,
  input  logic              a_ready,
  output logic [2:0]        a_op,
  output logic [SZ_W-1:0]   a_size,
  output logic [ADDR_W-1:0] a_addr,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  output logic              a_first,
  output logic              a_last,
  output logic              a_fwd
);
  localparam int CNT_W  = MAX_LG - MIN_LG + 2;
  localparam int CUT_LG = (FORCE_MIN != 0) ? MIN_LG : TGT_LG;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  total_beats, frag_beats, step, next_cnt, frag_off;
  logic [SZ_W-1:0]   frag_sz;
  logic [ADDR_W-1:0] base;
  logic              is_arith, has_data, burst_end, fire;

  always_comb begin
    is_arith    = (req_op == OP_ARITH);
    has_data    = op_carries_data(req_op);
    frag_sz     = SZ_W'(frag_lg(is_arith, int'(req_size), MIN_LG, CUT_LG, FORCE_MIN));
    total_beats = is_arith ? CNT_W'(1) : CNT_W'(beats_of(int'(req_size), MIN_LG));
    frag_beats  = CNT_W'(beats_of(int'(frag_sz), MIN_LG));
    step        = has_data ? CNT_W'(1) : frag_beats;
    next_cnt    = cnt_q + step;
    burst_end   = (next_cnt >= total_beats);
    frag_off    = cnt_q & ~(frag_beats - CNT_W'(1));
    base        = req_addr & ~((ADDR_W'(1) << req_size) - ADDR_W'(1));
  end

  assign fire      = a_valid & a_ready;
  assign a_valid   = req_valid;
  assign req_ready = a_ready & (has_data | burst_end);
  assign a_op      = req_op;
  assign a_size    = frag_sz;
  assign a_addr    = base + (ADDR_W'(frag_off) << MIN_LG);
  assign a_tag     = req_tag;
  assign a_data    = req_data;
  assign a_first   = (cnt_q < frag_beats);
  assign a_last    = ((cnt_q + frag_beats) >= total_beats);
  assign a_fwd     = op_returns_data(req_op) ? 1'b1 :
                     (ack_early(ACK_POLICY, req_op) ? a_first : a_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (fire) cnt_q <= burst_end ? '0 : next_cnt;
  end

  // R1: a header-only request leaves upstream only with its final fragment
  a_r1_pop_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !has_data) |-> a_last);

  // R3: successive fragments of a held header step by one fragment size
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !req_ready && !has_data) |=>
      (a_addr == $past(a_addr) + (ADDR_W'(1) << $past(frag_sz))));

  // R2: non-arithmetic fragments never exceed the cut size
  a_r2_size_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_op != 3'd4) |-> (int'(a_size) <= CUT_LG));

  // R5: arithmetic atomics are a single complete fragment
  a_r5_arith_single: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_op == 3'd4) |-> (a_first && a_last && req_ready == a_ready));

endmodule

// File: rtl/frag_rsp_merge.sv
module frag_rsp_merge
  import frag_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int TAG_W     = 4,
  parameter int SZ_W      = 4,
  parameter int MIN_LG    = 2,
  parameter int MAX_LG    = 6,
  parameter int HOLD_DENY = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_valid,
  output logic              d_ready,
  input  logic              d_has_data,
  input  logic [SZ_W-1:0]   d_size,
  input  logic [TAG_W-1:0]  d_tag,
  input  logic [DATA_W-1:0] d_data,
  input  logic              d_denied,
  input  logic              d_first,
  input  logic              d_last,
  input  logic              d_fwd,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_has_data,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_denied
);
  localparam int CNT_W = MAX_LG - MIN_LG + 2;

  logic [CNT_W-1:0] bcnt_q, frag_beats;
  logic             deny_q, acked_q;
  logic             burst_start, data_fire, ack_fire, ack_out;

  assign frag_beats  = CNT_W'(beats_of(int'(d_size), MIN_LG));
  assign burst_start = d_first && (bcnt_q == '0);
  assign d_ready     = rsp_ready | (!d_has_data & !d_fwd);
  assign data_fire   = d_valid & d_ready & d_has_data;
  assign ack_fire    = d_valid & d_ready & !d_has_data;
  assign ack_out     = ack_fire & d_fwd;

  assign rsp_valid    = d_valid & (d_has_data | d_fwd);
  assign rsp_has_data = d_has_data;
  assign rsp_tag      = d_tag;
  assign rsp_data     = d_data;
  assign rsp_denied   = ((HOLD_DENY != 0) && d_has_data && !burst_start) ? deny_q : d_denied;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt_q  <= '0;
      deny_q  <= 1'b0;
      acked_q <= 1'b0;
    end else begin
      if (data_fire) begin
        bcnt_q <= (bcnt_q + CNT_W'(1) >= frag_beats) ? '0 : bcnt_q + CNT_W'(1);
        if (burst_start) deny_q <= d_denied;
      end
      if (ack_fire) acked_q <= d_last ? 1'b0 : (acked_q | d_fwd);
    end
  end

  // R6: at most one acknowledgement per original write reaches the requester
  a_r6_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> !acked_q);

  // R10: within a held burst, status stays that of the burst's first beat
  a_r10_deny_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((HOLD_DENY != 0) && data_fire && !burst_start && $past(data_fire)) |->
      (rsp_denied == $past(rsp_denied)));

  // R9: every data beat offered by the target is offered to the requester
  a_r9_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && d_has_data) |-> (rsp_valid && d_ready == rsp_ready));

endmodule

// File: rtl/burst_fragmenter.sv
module burst_fragmenter
  import frag_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int TAG_W      = 4,
  parameter int SZ_W       = 4,
  parameter int MIN_LG     = 2,
  parameter int MAX_LG     = 6,
  parameter int TGT_LG     = 4,
  parameter int FORCE_MIN  = 0,
  parameter int ACK_POLICY = 0,
  parameter int HOLD_DENY  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [2:0]        up_op,
  input  logic [SZ_W-1:0]   up_size,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [TAG_W-1:0]  up_tag,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [2:0]        dn_op,
  output logic [SZ_W-1:0]   dn_size,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [TAG_W-1:0]  dn_tag,
  output logic [DATA_W-1:0] dn_data,
  output logic              dn_first,
  output logic              dn_last,
  output logic              dn_fwd,
  input  logic              tr_valid,
  output logic              tr_ready,
  input  logic              tr_has_data,
  input  logic [SZ_W-1:0]   tr_size,
  input  logic [TAG_W-1:0]  tr_tag,
  input  logic [DATA_W-1:0] tr_data,
  input  logic              tr_denied,
  input  logic              tr_first,
  input  logic              tr_last,
  input  logic              tr_fwd,
  output logic              rp_valid,
  input  logic              rp_ready,
  output logic              rp_has_data,
  output logic [TAG_W-1:0]  rp_tag,
  output logic [DATA_W-1:0] rp_data,
  output logic              rp_denied
);
  frag_op_e op_e;
  assign op_e = frag_op_e'(up_op);

  frag_req_split #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .SZ_W(SZ_W),
    .MIN_LG(MIN_LG), .MAX_LG(MAX_LG), .TGT_LG(TGT_LG),
    .FORCE_MIN(FORCE_MIN), .ACK_POLICY(ACK_POLICY)
  ) u_split (
    .clk(clk), .rst_n(rst_n),
    .req_valid(up_valid), .req_ready(up_ready), .req_op(op_e),
    .req_size(up_size), .req_addr(up_addr), .req_tag(up_tag), .req_data(up_data),
    .a_valid(dn_valid), .a_ready(dn_ready), .a_op(dn_op), .a_size(dn_size),
    .a_addr(dn_addr), .a_tag(dn_tag), .a_data(dn_data),
    .a_first(dn_first), .a_last(dn_last), .a_fwd(dn_fwd)
  );

  frag_rsp_merge #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .SZ_W(SZ_W),
    .MIN_LG(MIN_LG), .MAX_LG(MAX_LG), .HOLD_DENY(HOLD_DENY)
  ) u_merge (
    .clk(clk), .rst_n(rst_n),
    .d_valid(tr_valid), .d_ready(tr_ready), .d_has_data(tr_has_data),
    .d_size(tr_size), .d_tag(tr_tag), .d_data(tr_data), .d_denied(tr_denied),
    .d_first(tr_first), .d_last(tr_last), .d_fwd(tr_fwd),
    .rsp_valid(rp_valid), .rsp_ready(rp_ready), .rsp_has_data(rp_has_data),
    .rsp_tag(rp_tag), .rsp_data(rp_data), .rsp_denied(rp_denied)
  );

endmodule

// File: tb/burst_fragmenter_tb_top.sv
module burst_fragmenter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCFG = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        up_valid[NCFG], up_ready[NCFG];
  logic [2:0]  up_op[NCFG];
  logic [3:0]  up_size[NCFG];
  logic [15:0] up_addr[NCFG];
  logic [3:0]  up_tag[NCFG];
  logic [31:0] up_data[NCFG];
  logic        dn_valid[NCFG], dn_ready[NCFG];
  logic [2:0]  dn_op[NCFG];
  logic [3:0]  dn_size[NCFG];
  logic [15:0] dn_addr[NCFG];
  logic [3:0]  dn_tag[NCFG];
  logic [31:0] dn_data[NCFG];
  logic        dn_first[NCFG], dn_last[NCFG], dn_fwd[NCFG];
  logic        tr_valid[NCFG], tr_ready[NCFG], tr_has_data[NCFG];
  logic [3:0]  tr_size[NCFG];
  logic [3:0]  tr_tag[NCFG];
  logic [31:0] tr_data[NCFG];
  logic        tr_denied[NCFG], tr_first[NCFG], tr_last[NCFG], tr_fwd[NCFG];
  logic        rp_valid[NCFG], rp_ready[NCFG], rp_has_data[NCFG];
  logic [3:0]  rp_tag[NCFG];
  logic [31:0] rp_data[NCFG];
  logic        rp_denied[NCFG];

  // cfg 0: ack on last, cfg 1: forced minimum + ack all writes early + hold denied,
  // cfg 2: early ack for full writes only
  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    burst_fragmenter #(
      .FORCE_MIN((k == 1) ? 1 : 0),
      .HOLD_DENY((k == 1) ? 1 : 0),
      .ACK_POLICY(k)
    ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .up_valid(up_valid[k]), .up_ready(up_ready[k]), .up_op(up_op[k]),
      .up_size(up_size[k]), .up_addr(up_addr[k]), .up_tag(up_tag[k]), .up_data(up_data[k]),
      .dn_valid(dn_valid[k]), .dn_ready(dn_ready[k]), .dn_op(dn_op[k]), .dn_size(dn_size[k]),
      .dn_addr(dn_addr[k]), .dn_tag(dn_tag[k]), .dn_data(dn_data[k]),
      .dn_first(dn_first[k]), .dn_last(dn_last[k]), .dn_fwd(dn_fwd[k]),
      .tr_valid(tr_valid[k]), .tr_ready(tr_ready[k]), .tr_has_data(tr_has_data[k]),
      .tr_size(tr_size[k]), .tr_tag(tr_tag[k]), .tr_data(tr_data[k]), .tr_denied(tr_denied[k]),
      .tr_first(tr_first[k]), .tr_last(tr_last[k]), .tr_fwd(tr_fwd[k]),
      .rp_valid(rp_valid[k]), .rp_ready(rp_ready[k]), .rp_has_data(rp_has_data[k]),
      .rp_tag(rp_tag[k]), .rp_data(rp_data[k]), .rp_denied(rp_denied[k])
    );
  end

  int n_chk = 0;
  int n_err = 0;

  // fragment records taken from the downstream ports, replayed as target responses
  int         cap_n;
  logic [3:0] cap_sz[16];
  logic       cap_first[16], cap_last[16], cap_fwd[16];

  task automatic check(string rq, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic idle_all();
    for (int k = 0; k < NCFG; k++) begin
      up_valid[k] = 0; up_op[k] = 0; up_size[k] = 0; up_addr[k] = 0;
      up_tag[k] = 0; up_data[k] = 0; dn_ready[k] = 1; rp_ready[k] = 1;
      tr_valid[k] = 0; tr_has_data[k] = 0; tr_size[k] = 0; tr_tag[k] = 0;
      tr_data[k] = 0; tr_denied[k] = 0; tr_first[k] = 0; tr_last[k] = 0; tr_fwd[k] = 0;
    end
  endtask

  // header-only request (read or hint): expected fragment count from sizes
  task automatic issue_nodata(int k, int op, int sz, int addr, int tag, int exp_lg, string rq);
    int nfr = (sz > exp_lg) ? (1 << (sz - exp_lg)) : 1;
    int base = addr & ~((1 << sz) - 1);
    cap_n = 0;
    @(negedge clk);
    up_valid[k] = 1; up_op[k] = 3'(op); up_size[k] = 4'(sz);
    up_addr[k] = 16'(addr); up_tag[k] = 4'(tag);
    for (int i = 0; i < nfr; i++) begin
      #1;
      check(rq, "dn_valid", dn_valid[k], 1);
      check(rq, "dn_addr", dn_addr[k], base + i * (1 << exp_lg));
      check(rq, "dn_size", dn_size[k], exp_lg);
      check(rq, "dn_first", dn_first[k], (i == 0) ? 1 : 0);
      check(rq, "dn_last", dn_last[k], (i == nfr - 1) ? 1 : 0);
      check(rq, "up_ready", up_ready[k], (i == nfr - 1) ? 1 : 0);
      check(rq, "dn_tag", dn_tag[k], tag);
      cap_sz[cap_n] = dn_size[k]; cap_first[cap_n] = dn_first[k];
      cap_last[cap_n] = dn_last[k]; cap_fwd[cap_n] = dn_fwd[k];
      cap_n++;
      @(negedge clk);
    end
    up_valid[k] = 0;
  endtask

  // data-carrying request: nb beats, fb beats per fragment
  task automatic issue_write(int k, int op, int sz, int addr, int tag, int exp_lg,
                             int nb, int fb, string rq);
    int base = addr & ~((1 << sz) - 1);
    cap_n = 0;
    @(negedge clk);
    up_valid[k] = 1; up_op[k] = 3'(op); up_size[k] = 4'(sz);
    up_addr[k] = 16'(addr); up_tag[k] = 4'(tag);
    for (int i = 0; i < nb; i++) begin
      up_data[k] = 32'hA5000000 + 32'(i);
      #1;
      check(rq, "dn_data", dn_data[k], 32'hA5000000 + i);
      check(rq, "dn_addr", dn_addr[k], base + (i / fb) * fb * 4);
      check(rq, "dn_size", dn_size[k], exp_lg);
      check(rq, "dn_first", dn_first[k], (i < fb) ? 1 : 0);
      check(rq, "dn_last", dn_last[k], (i >= nb - fb) ? 1 : 0);
      check(rq, "up_ready", up_ready[k], 1);
      if (i % fb == 0) begin
        cap_sz[cap_n] = dn_size[k]; cap_first[cap_n] = dn_first[k];
        cap_last[cap_n] = dn_last[k]; cap_fwd[cap_n] = dn_fwd[k];
        cap_n++;
      end
      @(negedge clk);
    end
    up_valid[k] = 0;
  endtask

  // one acknowledgement per captured fragment; exactly one must reach the requester
  task automatic replay_acks(int k, int tag, int exp_idx, string rq);
    int seen = 0;
    int got = -1;
    for (int i = 0; i < cap_n; i++) begin
      @(negedge clk);
      tr_valid[k] = 1; tr_has_data[k] = 0; tr_size[k] = cap_sz[i]; tr_tag[k] = 4'(tag);
      tr_first[k] = cap_first[i]; tr_last[k] = cap_last[i]; tr_fwd[k] = cap_fwd[i];
      tr_denied[k] = 0;
      #1;
      if (rp_valid[k]) begin
        seen++; got = i;
        check(rq, "rp_tag", rp_tag[k], tag);
      end
    end
    @(negedge clk);
    tr_valid[k] = 0;
    check(rq, "ack count", seen, 1);
    check(rq, "ack fragment", got, exp_idx);
  endtask

  // data beats for each captured fragment; denied bit b of mask on beat b
  task automatic replay_read(int k, int tag, int mask, int hold, string rq);
    int b = 0;
    for (int i = 0; i < cap_n; i++) begin
      for (int j = 0; j < (1 << (int'(cap_sz[i]) - 2)); j++) begin
        @(negedge clk);
        tr_valid[k] = 1; tr_has_data[k] = 1; tr_size[k] = cap_sz[i]; tr_tag[k] = 4'(tag);
        tr_first[k] = cap_first[i]; tr_last[k] = cap_last[i]; tr_fwd[k] = cap_fwd[i];
        tr_data[k] = 32'hC0DE0000 + 32'(b); tr_denied[k] = mask[b];
        #1;
        check(rq, "rp_valid", rp_valid[k], 1);
        check(rq, "rp_data", rp_data[k], 32'hC0DE0000 + b);
        check(rq, "rp_tag", rp_tag[k], tag);
        check(rq, "rp_denied", rp_denied[k], hold ? mask[0] : mask[b]);
        b++;
      end
    end
    @(negedge clk);
    tr_valid[k] = 0; tr_has_data[k] = 0;
  endtask

  task automatic t_reset();
    for (int k = 0; k < NCFG; k++) begin
      check("R11", "dn_valid idle", dn_valid[k], 0);
      check("R11", "rp_valid idle", rp_valid[k], 0);
    end
  endtask

  task automatic t_read_split();
    issue_nodata(0, 0, 6, 16'h1234, 3, 4, "R1 R3 R11");   // 4 fragments from 0x1200
    replay_read(0, 3, 16'h0004, 0, "R9 R10");
    issue_nodata(0, 0, 3, 16'h0048, 5, 3, "R1");          // fits in one fragment
  endtask

  task automatic t_forced_min();
    issue_nodata(1, 5, 5, 16'h0100, 2, 2, "R2 R3");       // hint into 8 fragments
    replay_acks(1, 2, 7, "R8 hint");
    issue_write(1, 2, 4, 16'h0040, 6, 2, 4, 1, "R2 R4");
    replay_acks(1, 6, 0, "R7");
  endtask

  task automatic t_write_last();
    issue_write(0, 1, 5, 16'h0220, 7, 4, 8, 4, "R4");
    replay_acks(0, 7, 1, "R6");
  endtask

  task automatic t_full_only();
    issue_write(2, 1, 6, 16'h0000, 1, 4, 16, 4, "R4");
    replay_acks(2, 1, 0, "R8 full");
    issue_write(2, 2, 6, 16'h0000, 4, 4, 16, 4, "R4");
    replay_acks(2, 4, 3, "R8 partial");
    issue_nodata(2, 5, 5, 16'h0080, 9, 4, "R1");
    replay_acks(2, 9, 1, "R8 hint");
  endtask

  task automatic t_atomics();
    issue_write(0, 4, 3, 16'h001C, 8, 3, 1, 1, "R5");
    issue_write(1, 4, 3, 16'h0018, 8, 2, 1, 1, "R5 forced");
    issue_write(0, 3, 4, 16'h0030, 10, 4, 4, 4, "R4 logical");
    replay_read(0, 10, 16'h0000, 0, "R9");
  endtask

  task automatic t_hold_deny();
    issue_nodata(1, 0, 4, 16'h0200, 11, 2, "R2");
    replay_read(1, 11, 16'h0001, 1, "R10 first denied");
    issue_nodata(1, 0, 4, 16'h0210, 12, 2, "R2");
    replay_read(1, 12, 16'h000E, 1, "R10 later denied");
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle_all();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_read_split();
    t_forced_min();
    t_write_last();
    t_full_only();
    t_atomics();
    t_hold_deny();
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule